// File: doc/BRIEF.md
# In-Order Retire Control Unit

This block is the reorder buffer of an out-of-order back end. It is a circular array of slots. When an instruction is dispatched, the block reserves one slot for each of its micro-ops. It hands back a token, which is the index of the instruction's first slot. Later the execution side returns that token to mark the instruction finished. Each cycle the block walks forward from the oldest entry and retires finished instructions. It stops at the first one that has not finished, so retirement stays in program order.

For each cycle the retire port reports two values: how many instructions leave, and the sum of the rename temporaries they held, which the rename logic can then release. Dispatch logic uses `disp_ready` to ask whether an instruction of a given micro-op count fits this cycle. It also sees the free-slot count and the full and empty flags. A parameter caps how many instructions may retire in one cycle, and a cap of zero means no limit.

Top module: `retire_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `empty` is 1, `full` is 0, `free_slots` equals DEPTH and `ret_count` is 0.
- R2: An accepted dispatch reserves as many slots as its micro-op count, capped at DEPTH. `free_slots` drops by that amount, and it rises by the slots of the instructions that retire.
- R3: `disp_token` is the index of the instruction's first slot. The next instruction's first slot follows on directly, modulo DEPTH.
- R4: `disp_ready` is 1 exactly when `disp_uops` is nonzero and is no more than `free_slots`. A micro-op count of zero is never ready.
- R5: An instruction with more micro-ops than DEPTH is ready only when the buffer is empty. It then occupies all DEPTH slots.
- R6: Only completed instructions retire, oldest first. A completed instruction waits while any older one is still pending. A completion takes effect for retirement one cycle after `done_valid`.
- R7: At most RET_MAX instructions retire per cycle. With RET_MAX equal to 0 every completed instruction at the head retires in the same cycle.
- R8: `ret_tmps` is the sum of the `disp_tmps` values given at dispatch to the instructions that retire this cycle.
- R9: `full` is 1 exactly when `free_slots` is 0, and `empty` is 1 exactly when `free_slots` equals DEPTH.
- R10: A dispatch offered while `disp_ready` is 0 is ignored. It reserves no slot and does not move the token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_uops | input | UOP_W | Micro-op count of the offered instruction (also the availability query) |
| disp_tmps | input | TMP_W | Rename temporaries held by the instruction |
| disp_ready | output | 1 | Offered instruction fits now |
| disp_token | output | IDX_W | Token (first slot index) given to an accepted instruction |
| done_valid | input | 1 | Execution side marks an instruction complete |
| done_token | input | IDX_W | Token of the completed instruction |
| ret_count | output | CNT_W | Instructions retired this cycle |
| ret_tmps | output | TMP_W+CNT_W | Temporaries to release this cycle |
| free_slots | output | CNT_W | Unreserved slots |
| full | output | 1 | No slot free |
| empty | output | 1 | All slots free |

## Verification
A wrong head or tail pointer appears at the ports within one cycle, as a token that does not continue from the previous instruction. A slip in the free count shows up as an early or late `full`, `empty` or `disp_ready`. A stale micro-op count or completion bit makes the head walk land on a slot that is not the start of an instruction. The next cycle then reports a retire count or a temporaries sum that differs from a queue of instructions held outside the design. Two instances, one uncapped and one capped at two, are each compared against such a queue on every cycle.

// File: rtl/retire_ctrl_pkg.sv
// Package: helpers shared by the retire control unit.
// Assumes depth is a positive constant; indices are non-negative.
package retire_ctrl_pkg;

    // Circular index advance, modulo the buffer depth.
    function automatic int wrap_add(input int ptr, input int step, input int depth);
        return (ptr + step) % depth;
    endfunction

    // Number of retire lanes to unroll: a cap of zero means the whole buffer.
    function automatic int lane_count(input int depth, input int cap);
        if (cap == 0 || cap > depth)
            return depth;
        return cap;
    endfunction

endpackage

// File: rtl/retire_ctrl_alloc.sv
// Module: slot allocator. Owns the head and tail pointers and the free count,
// answers the availability query and turns an accepted request into a slot
// reservation. Assumes release never exceeds the occupied slots.
module retire_ctrl_alloc
    import retire_ctrl_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int UOP_W = 5,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [UOP_W-1:0] req_uops,
    input  logic [CNT_W-1:0] rel_slots,
    output logic             req_ok,
    output logic             accept,
    output logic [CNT_W-1:0] take_slots,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] free_cnt,
    output logic             full,
    output logic             empty
);

    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] free_q;

    // Slots the offered instruction would occupy (oversized ones take all).
    always_comb begin
        if (int'(req_uops) > DEPTH)
            take_slots = CNT_W'(DEPTH);
        else
            take_slots = CNT_W'(req_uops);
    end

    assign empty  = (int'(free_q) == DEPTH);
    assign full   = (free_q == '0);
    assign req_ok = (req_uops != '0) && ((int'(req_uops) <= int'(free_q)) || empty);
    assign accept = req_valid && req_ok;

    // Pointer and free-count update for dispatch and retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            free_q <= CNT_W'(DEPTH);
        end else begin
            head_q <= IDX_W'(wrap_add(int'(head_q), int'(rel_slots), DEPTH));
            if (accept)
                tail_q <= IDX_W'(wrap_add(int'(tail_q), int'(take_slots), DEPTH));
            free_q <= free_q + rel_slots - (accept ? take_slots : CNT_W'(0));
        end
    end

    assign head     = head_q;
    assign tail     = tail_q;
    assign free_cnt = free_q;

    // A reservation never takes more than the free slots.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (take_slots <= free_q));

    // Full and empty never hold together.
    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

// File: rtl/retire_ctrl_scan.sv
// Module: head walk. Starting at the head, retires consecutive completed
// instructions up to the lane limit and totals their slots and temporaries.
// Assumes per-slot size and temporaries are valid at instruction starts.
module retire_ctrl_scan
    import retire_ctrl_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TMP_W = 4,
    parameter int LANES = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int SUM_W = TMP_W + CNT_W
) (
    input  logic [IDX_W-1:0] head,
    input  logic [CNT_W-1:0] occupied,
    input  logic [DEPTH-1:0] done_vec,
    input  logic [CNT_W-1:0] size_arr [DEPTH],
    input  logic [TMP_W-1:0] tmp_arr  [DEPTH],
    output logic [CNT_W-1:0] ret_count,
    output logic [CNT_W-1:0] ret_slots,
    output logic [SUM_W-1:0] ret_tmps
);

    // Walk the in-order chain of completed instructions from the head.
    always_comb begin
        logic [IDX_W-1:0] ptr;
        logic             go;
        ptr       = head;
        go        = 1'b1;
        ret_count = '0;
        ret_slots = '0;
        ret_tmps  = '0;
        for (int k = 0; k < LANES; k++) begin
            if (go && (ret_slots < occupied) && done_vec[ptr]) begin
                ret_count = ret_count + CNT_W'(1);
                ret_slots = ret_slots + size_arr[ptr];
                ret_tmps  = ret_tmps + SUM_W'(tmp_arr[ptr]);
                ptr       = IDX_W'(wrap_add(int'(ptr), int'(size_arr[ptr]), DEPTH));
            end else begin
                go = 1'b0;
            end
        end
    end

endmodule

// File: rtl/retire_ctrl.sv
// Module: in-order retire control unit (reorder buffer). Reserves one slot
// per micro-op at dispatch, records completion by token and retires finished
// instructions from the head in program order, up to RET_MAX per cycle
// (0 = unlimited). Assumes done_token names an in-flight instruction.
module retire_ctrl
    import retire_ctrl_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int UOP_W   = 5,
    parameter int TMP_W   = 4,
    parameter int RET_MAX = 0,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int SUM_W = TMP_W + CNT_W,
    localparam int LANES = lane_count(DEPTH, RET_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic [UOP_W-1:0] disp_uops,
    input  logic [TMP_W-1:0] disp_tmps,
    output logic             disp_ready,
    output logic [IDX_W-1:0] disp_token,
    input  logic             done_valid,
    input  logic [IDX_W-1:0] done_token,
    output logic [CNT_W-1:0] ret_count,
    output logic [SUM_W-1:0] ret_tmps,
    output logic [CNT_W-1:0] free_slots,
    output logic             full,
    output logic             empty
);

    logic             accept;
    logic [CNT_W-1:0] take_slots, rel_slots, free_cnt;
    logic [IDX_W-1:0] head, tail;
    logic [DEPTH-1:0] done_vec;
    logic [CNT_W-1:0] size_arr [DEPTH];
    logic [TMP_W-1:0] tmp_arr  [DEPTH];

    retire_ctrl_alloc #(.DEPTH(DEPTH), .UOP_W(UOP_W)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (disp_valid),
        .req_uops   (disp_uops),
        .rel_slots  (rel_slots),
        .req_ok     (disp_ready),
        .accept     (accept),
        .take_slots (take_slots),
        .head       (head),
        .tail       (tail),
        .free_cnt   (free_cnt),
        .full       (full),
        .empty      (empty)
    );

    retire_ctrl_scan #(.DEPTH(DEPTH), .TMP_W(TMP_W), .LANES(LANES)) u_scan (
        .head      (head),
        .occupied  (CNT_W'(DEPTH) - free_cnt),
        .done_vec  (done_vec),
        .size_arr  (size_arr),
        .tmp_arr   (tmp_arr),
        .ret_count (ret_count),
        .ret_slots (rel_slots),
        .ret_tmps  (ret_tmps)
    );

    // Per-slot record: instruction size, temporaries and completion flag.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [CNT_W-1:0] size_r;
        logic [TMP_W-1:0] tmp_r;
        logic             done_r;

        // Capture the record at dispatch; set completion from the token.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                size_r <= '0;
                tmp_r  <= '0;
                done_r <= 1'b0;
            end else if (accept && (tail == IDX_W'(s))) begin
                size_r <= take_slots;
                tmp_r  <= disp_tmps;
                done_r <= 1'b0;
            end else if (done_valid && (done_token == IDX_W'(s))) begin
                done_r <= 1'b1;
            end
        end

        assign size_arr[s] = size_r;
        assign tmp_arr[s]  = tmp_r;
        assign done_vec[s] = done_r;
    end

    assign disp_token = tail;
    assign free_slots = free_cnt;

    // Retirement only starts from a completed head instruction.
    assert_head_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_count != '0) |-> done_vec[head]);

    // Nothing retires from an empty buffer.
    assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (ret_count == '0 && ret_tmps == '0));

    // Per-cycle retire cap is respected when one is set.
    assert_retire_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (RET_MAX == 0) || (int'(ret_count) <= RET_MAX));

    // A retire never frees more slots than are occupied.
    assert_release_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rel_slots) + int'(free_cnt)) <= DEPTH);

endmodule

// File: tb/test_retire_ctrl.sv
// Bench agent: drives one retire_ctrl instance with random traffic and
// compares every output each cycle against a queue-based model.
module retire_ctrl_agent #(
    parameter int DEPTH  = 8,
    parameter int UOP_W  = 4,
    parameter int TMP_W  = 3,
    parameter int CAP    = 0,
    parameter int CYCLES = 3000,
    parameter int SEED   = 1,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int SUM_W = TMP_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             dv,
    output logic [UOP_W-1:0] du,
    output logic [TMP_W-1:0] dt,
    output logic             cv,
    output logic [IDX_W-1:0] ctok,
    input  logic             rdy,
    input  logic [IDX_W-1:0] tok,
    input  logic [CNT_W-1:0] rcnt,
    input  logic [SUM_W-1:0] rtmp,
    input  logic [CNT_W-1:0] free,
    input  logic             full,
    input  logic             empty,
    output int               n_chk,
    output int               n_fail,
    output logic             finished
);

    int q_tok[$];
    int q_occ[$];
    int q_tmp[$];
    bit q_done[$];
    int m_free;
    int m_tail;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (cap %0d) actual=%0d expected=%0d", tag, CAP, act, exp);
        end
    endtask

    initial begin
        dv = 0; du = '0; dt = '0; cv = 0; ctok = '0;
        n_chk = 0; n_fail = 0; finished = 0;
        m_free = DEPTH; m_tail = 0;
        void'($urandom(SEED));
        wait (rst_n === 1'b1);
        @(negedge clk);
        #1;
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 free", int'(free), DEPTH);
        chk("R1 ret_count", int'(rcnt), 0);
        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            int dr, cr, sel, ci, n, s, occ;
            bit exp_rdy;
            @(negedge clk);
            dr = (cyc < CYCLES / 2) ? 70 : 20;
            cr = (cyc < CYCLES / 2) ? 45 : 90;
            dv = ($urandom_range(99) < dr);
            sel = $urandom_range(99);
            if (sel < 5)
                du = '0;
            else if (sel < 20)
                du = UOP_W'($urandom_range((1 << UOP_W) - 1, DEPTH + 1));
            else
                du = UOP_W'($urandom_range(4, 1));
            dt = TMP_W'($urandom_range((1 << TMP_W) - 1));
            ci = -1;
            cv = 0;
            if (q_tok.size() > 0 && $urandom_range(99) < cr) begin
                ci = $urandom_range(q_tok.size() - 1);
                cv = 1;
                ctok = IDX_W'(q_tok[ci]);
            end
            #1;
            exp_rdy = (du != 0) && ((int'(du) <= m_free) || (m_free == DEPTH));
            chk((int'(du) > DEPTH) ? "R5 ready" : "R4 ready", int'(rdy), int'(exp_rdy));
            if (exp_rdy)
                chk("R3 token", int'(tok), m_tail);
            chk("R2 R10 free", int'(free), m_free);
            chk("R9 full", int'(full), int'(m_free == 0));
            chk("R9 empty", int'(empty), int'(m_free == DEPTH));
            n = 0;
            s = 0;
            for (int i = 0; i < q_tok.size(); i++) begin
                if (CAP != 0 && n == CAP) break;
                if (!q_done[i]) break;
                n++;
                s += q_tmp[i];
            end
            chk("R6 R7 ret_count", int'(rcnt), n);
            chk("R8 ret_tmps", int'(rtmp), s);
            @(posedge clk);
            if (ci >= 0) q_done[ci] = 1'b1;
            for (int i = 0; i < n; i++) begin
                m_free += q_occ[0];
                void'(q_tok.pop_front());
                void'(q_occ.pop_front());
                void'(q_tmp.pop_front());
                void'(q_done.pop_front());
            end
            if (dv && exp_rdy) begin
                occ = (int'(du) > DEPTH) ? DEPTH : int'(du);
                q_tok.push_back(m_tail);
                q_occ.push_back(occ);
                q_tmp.push_back(int'(dt));
                q_done.push_back(1'b0);
                m_free -= occ;
                m_tail = (m_tail + occ) % DEPTH;
            end
        end
        @(negedge clk);
        dv = 0;
        cv = 0;
        finished = 1;
    end

endmodule

// Bench top: one uncapped and one capped instance, watchdog and summary.
module test_retire_ctrl;
    localparam int DEPTH = 8;
    localparam int UOP_W = 4;
    localparam int TMP_W = 3;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SUM_W = TMP_W + CNT_W;

    logic clk = 0;
    logic rst_n = 0;
    always #2 clk = ~clk;

    logic             a_dv, b_dv, a_cv, b_cv, a_rdy, b_rdy;
    logic [UOP_W-1:0] a_du, b_du;
    logic [TMP_W-1:0] a_dt, b_dt;
    logic [IDX_W-1:0] a_ct, b_ct, a_tok, b_tok;
    logic [CNT_W-1:0] a_rc, b_rc, a_fr, b_fr;
    logic [SUM_W-1:0] a_rt, b_rt;
    logic             a_full, b_full, a_empty, b_empty;
    int               a_chk, a_fail, b_chk, b_fail;
    logic             a_fin, b_fin;

    retire_ctrl #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TMP_W(TMP_W), .RET_MAX(0)) i_retire_ctrl (
        .clk(clk), .rst_n(rst_n), .disp_valid(a_dv), .disp_uops(a_du), .disp_tmps(a_dt),
        .disp_ready(a_rdy), .disp_token(a_tok), .done_valid(a_cv), .done_token(a_ct),
        .ret_count(a_rc), .ret_tmps(a_rt), .free_slots(a_fr), .full(a_full), .empty(a_empty));

    retire_ctrl #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TMP_W(TMP_W), .RET_MAX(2)) i_retire_ctrl_cap2 (
        .clk(clk), .rst_n(rst_n), .disp_valid(b_dv), .disp_uops(b_du), .disp_tmps(b_dt),
        .disp_ready(b_rdy), .disp_token(b_tok), .done_valid(b_cv), .done_token(b_ct),
        .ret_count(b_rc), .ret_tmps(b_rt), .free_slots(b_fr), .full(b_full), .empty(b_empty));

    retire_ctrl_agent #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TMP_W(TMP_W), .CAP(0), .SEED(11)) u_agent_a (
        .clk(clk), .rst_n(rst_n), .dv(a_dv), .du(a_du), .dt(a_dt), .cv(a_cv), .ctok(a_ct),
        .rdy(a_rdy), .tok(a_tok), .rcnt(a_rc), .rtmp(a_rt), .free(a_fr), .full(a_full),
        .empty(a_empty), .n_chk(a_chk), .n_fail(a_fail), .finished(a_fin));

    retire_ctrl_agent #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TMP_W(TMP_W), .CAP(2), .SEED(23)) u_agent_b (
        .clk(clk), .rst_n(rst_n), .dv(b_dv), .du(b_du), .dt(b_dt), .cv(b_cv), .ctok(b_ct),
        .rdy(b_rdy), .tok(b_tok), .rcnt(b_rc), .rtmp(b_rt), .free(b_fr), .full(b_full),
        .empty(b_empty), .n_chk(b_chk), .n_fail(b_fail), .finished(b_fin));

    initial begin
        int wd_fail;
        wd_fail = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (a_fin && b_fin) break;
        end
        if (!(a_fin && b_fin)) begin
            wd_fail = 1;
            $display("FAIL watchdog: run hung, actual=0 expected=1 finished");
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 a_chk + b_chk + wd_fail, a_fail + b_fail + wd_fail);
        $finish;
    end
endmodule